// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Selectable Frame Format

A full-duplex serial line unit. The transmit side and the receive side run independently, so both can be busy at the same moment. Each side has two storage stages. On the transmit side a holding register sits in front of the frame shifter. On the receive side the assembled character moves into a holding register that the consumer reads. This lets the next character be queued, or the last one collected, while a frame is still on the wire.

Every frame starts with one low start bit. The data bits follow, lowest bit first, and there are 7 or 8 of them. An even or odd parity bit may come next. The frame ends with one or two high stop bits, and the line rests high between frames. Bit timing comes from a 16x tick, with 16 ticks in each bit. The tick comes either from an internal programmable divider or from rising edges on an external clock pin that runs at sixteen times the bit rate. In internal mode the pin can instead be driven with a clock at the bit rate. That clock is low for the first half of each transmitted bit and rises at mid-bit.

The receiver starts on a high-to-low step of the idle line and checks the start bit half a bit later. It then samples each following bit at its centre. It reports framing, parity and overrun conditions beside the received character.

Top module: `async_serial_xcvr`

## Requirements
- R1: `txd` is 1 out of reset and between frames. A frame is sent as bit 0 = start (0), then the data bits LSB first, then the parity bit if enabled, then 1 or 2 stop bits (1), with `cfg_two_stop`=1 selecting two. `cfg_eight`=1 selects 8 data bits and 0 selects 7 (`tx_data[6:0]`).
- R2: With `cfg_par_en`=1, the parity bit is the XOR of the selected data bits when `cfg_par_odd`=0 (even), and its inverse when `cfg_par_odd`=1 (odd). Bit 7 is not included in 7-bit mode.
- R3: A correctly formed frame on `rxd` sets `rx_full` with the data in `rx_data`, and `rx_ferr` and `rx_perr` stay 0. In 7-bit mode `rx_data[7]` reads 0. A one-cycle `rx_rd` pulse clears `rx_full` and all three error flags.
- R4: Out of reset `tx_empty`=1 and `tx_end`=1. A `tx_wr` while `tx_empty`=1 stores the character, so `tx_empty`=0 on the next cycle and `tx_end`=0. When the shifter is idle, the character moves into it one cycle later: `tx_empty` returns to 1 and the start bit appears. A character waiting at the end of a frame is sent straight after it. `tx_end` becomes 1 once the last stop bit is complete and nothing is waiting.
- R5: A `tx_wr` while `tx_empty`=0 is ignored: the character it carries is never sent.
- R6: If a frame completes while `rx_full`=1 and no read is pending, `rx_ovr` becomes 1 and `rx_data` keeps the unread character.
- R7: A first stop bit sampled low sets `rx_ferr` together with `rx_full`.
- R8: A received parity bit that does not match the parity of the received data sets `rx_perr` together with `rx_full`.
- R9: A low pulse on `rxd` that has ended by mid-bit of the start bit is dropped. It sets no flag, and a proper frame after it is received normally.
- R10: With `cfg_ext_clk`=0, the tick period is `cfg_div`+1 clocks, so a bit lasts 16*(`cfg_div`+1) clocks.
- R11: With `cfg_ext_clk`=1, each rising edge of `sclk_in` is one tick, so a bit lasts 16 `sclk_in` periods. `sclk_oe` is then 0.
- R12: `sclk_oe` = `cfg_clk_out_en` AND NOT `cfg_ext_clk`. During a frame, `sclk_out` is 0 for ticks 0..7 of each bit and 1 for ticks 8..15. It is 1 while the transmitter is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Internal tick divider; tick every cfg_div+1 clocks |
| cfg_ext_clk | input | 1 | 1: tick from external sclk_in edges |
| cfg_clk_out_en | input | 1 | Drive bit-rate clock on the pin in internal mode |
| cfg_eight | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_two_stop | input | 1 | 1: two stop bits |
| sclk_in | input | 1 | External 16x clock |
| sclk_out | output | 1 | Bit-rate clock output |
| sclk_oe | output | 1 | Output enable for the clock pin |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | 8 | Character to send |
| tx_empty | output | 1 | Transmit holding register can take a character |
| tx_end | output | 1 | Transmitter idle with nothing waiting |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_rd | input | 1 | Acknowledge of the received character |
| rx_data | output | 8 | Received character |
| rx_full | output | 1 | Received character waiting |
| rx_ferr | output | 1 | Framing error on the waiting character |
| rx_perr | output | 1 | Parity error on the waiting character |
| rx_ovr | output | 1 | A frame was lost while a character waited |

## Verification
The bench builds the block with its default DIV_W of 8. It runs mostly at `cfg_div`=0, where one tick falls on every clock and a bit lasts exactly 16 clocks. With that timing the sweep can check every bit of `txd` and both halves of `sclk_out` at fixed clock offsets, across all twelve frame formats and across all 256 characters in 8-bit no-parity mode. A divider of 2 and a 4-clock external clock then stretch the bit, and the measured low time of a zero character must fall inside the window that tick phase allows. Error frames, runt start pulses and overrun are driven on `rxd` directly or through the transmitter looped back.

// File: rtl/sdu_pkg.sv
package sdu_pkg;
    localparam int OVS     = 16;
    localparam int TCNT_W  = $clog2(OVS);
    localparam int DATA_W  = 8;
    localparam int IDX_W   = $clog2(DATA_W);
    localparam int FRAME_W = DATA_W + 4;
    localparam int BCNT_W  = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic eight;
        logic par_en;
        logic par_odd;
        logic two_stop;
    } fmt_t;

    typedef enum logic { TX_IDLE, TX_SHIFT } tx_st_e;
    typedef enum logic [1:0] { RX_IDLE, RX_START, RX_BITS } rx_st_e;

    function automatic logic par_bit(logic [DATA_W-1:0] d, logic eight, logic odd);
        logic p;
        p = ^(eight ? d : {1'b0, d[DATA_W-2:0]});
        return p ^ odd;
    endfunction

    function automatic logic [BCNT_W-1:0] n_data(logic eight);
        return eight ? BCNT_W'(DATA_W) : BCNT_W'(DATA_W - 1);
    endfunction

    function automatic logic [FRAME_W-1:0] build_frame(logic [DATA_W-1:0] d, fmt_t f);
        logic [FRAME_W-1:0] fr;
        int unsigned n;
        n = f.eight ? DATA_W : DATA_W - 1;
        fr = '1;
        fr[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++)
            if (i < int'(n)) fr[i+1] = d[i];
        if (f.par_en) fr[n+1] = par_bit(d, f.eight, f.par_odd);
        return fr;
    endfunction

    function automatic logic [BCNT_W-1:0] frame_len(fmt_t f);
        return BCNT_W'(2) + n_data(f.eight) + BCNT_W'(f.par_en) + BCNT_W'(f.two_stop);
    endfunction
endpackage

// File: rtl/sdu_tick_gen.sv
module sdu_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_ext_clk,
    input  logic             sclk_in,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [2:0]       sync;
        logic             tick;
    } tg_t;

    tg_t q, d;

    always_comb begin
        d = q;
        d.sync = {q.sync[1:0], sclk_in};
        if (q.cnt == cfg_div) begin
            d.cnt = '0;
            d.tick = !cfg_ext_clk;
        end else begin
            d.cnt = q.cnt + 1'b1;
            d.tick = 1'b0;
        end
        if (cfg_ext_clk) d.tick = q.sync[1] & ~q.sync[2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick = q.tick;

    // R11: an external edge gives a single-cycle tick
    assert_ext_tick_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ext_clk && $past(cfg_ext_clk) && q.tick) |=> !q.tick);
endmodule

// File: rtl/sdu_tx.sv
module sdu_tx
    import sdu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  fmt_t              cfg,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_empty,
    output logic              tx_end,
    output logic              txd,
    output logic              bit_clk
);
    typedef struct packed {
        tx_st_e              st;
        logic [DATA_W-1:0]   hold;
        logic                hold_vld;
        logic [FRAME_W-1:0]  sh;
        logic [BCNT_W-1:0]   left;
        logic [TCNT_W-1:0]   tcnt;
        logic                end_f;
    } tx_s_t;

    tx_s_t q, d;
    logic  load;

    always_comb begin
        d = q;
        load = 1'b0;
        case (q.st)
            TX_IDLE: load = q.hold_vld;
            TX_SHIFT: begin
                if (tick) begin
                    if (q.tcnt == TCNT_W'(OVS - 1)) begin
                        d.tcnt = '0;
                        if (q.left == '0) begin
                            if (q.hold_vld) begin
                                load = 1'b1;
                            end else begin
                                d.st = TX_IDLE;
                                d.end_f = 1'b1;
                            end
                        end else begin
                            d.sh = {1'b1, q.sh[FRAME_W-1:1]};
                            d.left = q.left - 1'b1;
                        end
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
            end
            default: d.st = TX_IDLE;
        endcase
        if (load) begin
            d.st = TX_SHIFT;
            d.sh = build_frame(q.hold, cfg);
            d.left = frame_len(cfg) - 1'b1;
            d.tcnt = '0;
            d.hold_vld = 1'b0;
        end
        if (tx_wr && !q.hold_vld) begin
            d.hold = tx_data;
            d.hold_vld = 1'b1;
            d.end_f = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
            q.sh <= '1;
            q.end_f <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign txd      = q.sh[0];
    assign tx_empty = !q.hold_vld;
    assign tx_end   = q.end_f;
    assign bit_clk  = (q.st == TX_IDLE) ? 1'b1 : q.tcnt[TCNT_W-1];

    assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == TX_IDLE) |-> txd);

    assert_empty_on_move_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == TX_IDLE && q.hold_vld) |=> (!q.hold_vld && q.st == TX_SHIFT && !txd));

    assert_end_implies_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q.end_f |-> !q.hold_vld);
endmodule

// File: rtl/sdu_rx.sv
module sdu_rx
    import sdu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cfg_eight,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              rxd,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              rx_ferr,
    output logic              rx_perr,
    output logic              rx_ovr
);
    typedef struct packed {
        logic [1:0]          sync;
        logic                prev;
        rx_st_e              st;
        logic [TCNT_W-1:0]   tcnt;
        logic [BCNT_W-1:0]   idx;
        logic [DATA_W-1:0]   sh;
        logic                par;
        logic [DATA_W-1:0]   data;
        logic                full;
        logic                ferr;
        logic                perr;
        logic                ovr;
    } rx_s_t;

    rx_s_t             q, d;
    logic              rxs;
    logic              full_eff;
    logic [BCNT_W-1:0] nd;

    assign rxs = q.sync[1];
    assign nd  = n_data(cfg_eight);

    always_comb begin
        d = q;
        d.sync = {q.sync[0], rxd};
        full_eff = q.full & ~rx_rd;
        if (rx_rd) begin
            d.full = 1'b0;
            d.ferr = 1'b0;
            d.perr = 1'b0;
            d.ovr  = 1'b0;
        end
        if (tick) begin
            d.prev = rxs;
            case (q.st)
                RX_IDLE: begin
                    if (q.prev && !rxs) begin
                        d.st = RX_START;
                        d.tcnt = '0;
                        d.idx = '0;
                        d.sh = '0;
                    end
                end
                RX_START: begin
                    if (q.tcnt == TCNT_W'(OVS/2 - 1)) begin
                        d.tcnt = '0;
                        d.st = rxs ? RX_IDLE : RX_BITS;
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
                RX_BITS: begin
                    if (q.tcnt == TCNT_W'(OVS - 1)) begin
                        d.tcnt = '0;
                        d.idx = q.idx + 1'b1;
                        if (q.idx < nd) begin
                            d.sh[q.idx[IDX_W-1:0]] = rxs;
                        end else if (q.idx == nd && cfg_par_en) begin
                            d.par = rxs;
                        end else begin
                            d.st = RX_IDLE;
                            if (full_eff) begin
                                d.ovr = 1'b1;
                            end else begin
                                d.data = q.sh;
                                d.full = 1'b1;
                                d.ferr = !rxs;
                                d.perr = cfg_par_en &&
                                         (q.par != par_bit(q.sh, cfg_eight, cfg_par_odd));
                            end
                        end
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
                default: d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
            q.sync <= '1;
            q.prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rx_data = q.data;
    assign rx_full = q.full;
    assign rx_ferr = q.ferr;
    assign rx_perr = q.perr;
    assign rx_ovr  = q.ovr;

    assert_keep_unread_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.full && !rx_rd) |=> $stable(q.data));

    assert_ovr_with_char_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q.ovr |-> q.full);

    assert_ferr_with_char_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q.ferr |-> q.full);

    assert_perr_with_char_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q.perr |-> q.full);

    assert_glitch_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == RX_START && tick && q.tcnt == TCNT_W'(OVS/2 - 1) && rxs) |=> (q.st == RX_IDLE));
endmodule

// File: rtl/async_serial_xcvr.sv
module async_serial_xcvr
    import sdu_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_ext_clk,
    input  logic             cfg_clk_out_en,
    input  logic             cfg_eight,
    input  logic             cfg_par_en,
    input  logic             cfg_par_odd,
    input  logic             cfg_two_stop,
    input  logic             sclk_in,
    output logic             sclk_out,
    output logic             sclk_oe,
    input  logic             tx_wr,
    input  logic [7:0]       tx_data,
    output logic             tx_empty,
    output logic             tx_end,
    output logic             txd,
    input  logic             rxd,
    input  logic             rx_rd,
    output logic [7:0]       rx_data,
    output logic             rx_full,
    output logic             rx_ferr,
    output logic             rx_perr,
    output logic             rx_ovr
);
    logic tick;
    fmt_t fmt;

    assign fmt = '{eight: cfg_eight, par_en: cfg_par_en,
                   par_odd: cfg_par_odd, two_stop: cfg_two_stop};

    sdu_tick_gen #(.DIV_W(DIV_W)) tick_i (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_ext_clk(cfg_ext_clk),
        .sclk_in(sclk_in), .tick(tick)
    );

    sdu_tx tx_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(fmt),
        .tx_wr(tx_wr), .tx_data(tx_data), .tx_empty(tx_empty), .tx_end(tx_end),
        .txd(txd), .bit_clk(sclk_out)
    );

    sdu_rx rx_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_eight(cfg_eight),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .rxd(rxd),
        .rx_rd(rx_rd), .rx_data(rx_data), .rx_full(rx_full), .rx_ferr(rx_ferr),
        .rx_perr(rx_perr), .rx_ovr(rx_ovr)
    );

    assign sclk_oe = cfg_clk_out_en & ~cfg_ext_clk;
endmodule

// File: tb/async_serial_xcvr_tb_top.sv
`timescale 1ns/1ps
module async_serial_xcvr_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_div = 8'd0;
    logic       cfg_ext_clk = 1'b0, cfg_clk_out_en = 1'b1;
    logic       cfg_eight = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
    logic       sclk_in = 1'b0;
    logic       sclk_out, sclk_oe;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = 8'd0;
    logic       tx_empty, tx_end, txd;
    logic       loop_sel = 1'b1, drv = 1'b1;
    logic       rxd;
    logic       rx_rd = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, rx_ferr, rx_perr, rx_ovr;
    logic       ext_run = 1'b0;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;
    assign rxd = loop_sel ? txd : drv;

    always begin
        if (ext_run) begin
            sclk_in = 1'b1; repeat (2) @(posedge clk);
            sclk_in = 1'b0; repeat (2) @(posedge clk);
        end else begin
            @(posedge clk);
        end
    end

    async_serial_xcvr dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_ext_clk(cfg_ext_clk),
        .cfg_clk_out_en(cfg_clk_out_en), .cfg_eight(cfg_eight), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop), .sclk_in(sclk_in),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .tx_wr(tx_wr), .tx_data(tx_data),
        .tx_empty(tx_empty), .tx_end(tx_end), .txd(txd), .rxd(rxd), .rx_rd(rx_rd),
        .rx_data(rx_data), .rx_full(rx_full), .rx_ferr(rx_ferr), .rx_perr(rx_perr),
        .rx_ovr(rx_ovr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic exp_par(input logic [7:0] d);
        logic [7:0] m;
        m = cfg_eight ? d : (d & 8'h7F);
        return (^m) ^ cfg_par_odd;
    endfunction

    function automatic logic [11:0] exp_frame(input logic [7:0] d);
        logic [11:0] f;
        int n;
        n = cfg_eight ? 8 : 7;
        f = '1;
        f[0] = 1'b0;
        for (int i = 0; i < n; i++) f[i+1] = d[i];
        if (cfg_par_en) f[n+1] = exp_par(d);
        return f;
    endfunction

    function automatic int exp_len();
        return 2 + (cfg_eight ? 8 : 7) + int'(cfg_par_en) + int'(cfg_two_stop);
    endfunction

    task automatic write_tx(input logic [7:0] d);
        @(negedge clk); tx_wr = 1'b1; tx_data = d;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic read_rx();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic wait_full(input string req);
        int t = 0;
        while (!rx_full && t < 2000) begin @(negedge clk); t++; end
        chk(rx_full, req, int'(rx_full), 1);
    endtask

    task automatic wait_tx_end();
        int t = 0;
        while (!tx_end && t < 3000) begin @(negedge clk); t++; end
        chk(tx_end, "R4", int'(tx_end), 1);
    endtask

    task automatic wait_start();
        int t = 0;
        while (txd && t < 100) begin @(negedge clk); t++; end
        chk(!txd, "R1", int'(txd), 0);
    endtask

    // One frame at one tick per clock: line bits, clock-out halves, looped-back receive
    task automatic xfer(input logic [7:0] d);
        logic [11:0] fr;
        int len;
        logic [7:0] ed;
        fr = exp_frame(d);
        len = exp_len();
        ed = cfg_eight ? d : (d & 8'h7F);
        write_tx(d);
        @(negedge clk);
        wait_start();
        for (int b = 0; b < len; b++) begin
            repeat (4) @(negedge clk);
            chk(sclk_out == 1'b0, "R12", int'(sclk_out), 0);
            repeat (4) @(negedge clk);
            chk(txd == fr[b], "R1", int'(txd), int'(fr[b]));
            chk(sclk_out == 1'b1, "R12", int'(sclk_out), 1);
            repeat (8) @(negedge clk);
        end
        wait_full("R3");
        chk(rx_data == ed, "R3", int'(rx_data), int'(ed));
        chk(!rx_perr, "R2", int'(rx_perr), 0);
        chk(!rx_ferr, "R3", int'(rx_ferr), 0);
        read_rx();
        chk(!rx_full, "R3", int'(rx_full), 0);
        wait_tx_end();
    endtask

    task automatic drive_raw(input logic [7:0] d, input bit bad_par, input bit stop_v);
        loop_sel = 1'b0;
        @(negedge clk);
        drv = 1'b0; repeat (16) @(negedge clk);
        for (int i = 0; i < 8; i++) begin drv = d[i]; repeat (16) @(negedge clk); end
        if (cfg_par_en) begin drv = exp_par(d) ^ bad_par; repeat (16) @(negedge clk); end
        drv = stop_v; repeat (16) @(negedge clk);
        drv = 1'b1; repeat (32) @(negedge clk);
    endtask

    task automatic measure_zero(input int lo, input int hi, input string req);
        int cyc = 0;
        write_tx(8'h00);
        @(negedge clk);
        wait_start();
        while (!txd && cyc < 2000) begin @(negedge clk); cyc++; end
        chk(cyc >= lo && cyc <= hi, req, cyc, hi);
        wait_full(req);
        chk(rx_data == 8'h00, req, int'(rx_data), 0);
        read_rx();
        wait_tx_end();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(txd, "R1", int'(txd), 1);
        chk(tx_empty, "R4", int'(tx_empty), 1);
        chk(tx_end, "R4", int'(tx_end), 1);
        chk(!rx_full, "R3", int'(rx_full), 0);
        chk(sclk_oe, "R12", int'(sclk_oe), 1);
        chk(sclk_out, "R12", int'(sclk_out), 1);

        // all twelve formats, sixteen characters each
        for (int e = 0; e < 2; e++)
            for (int pm = 0; pm < 3; pm++)
                for (int s = 0; s < 2; s++) begin
                    cfg_eight = e[0]; cfg_par_en = (pm != 0); cfg_par_odd = (pm == 2);
                    cfg_two_stop = s[0];
                    for (int k = 0; k < 16; k++) xfer(8'((k * 37 + pm * 11 + e * 5 + s) & 255));
                end

        // every character, 8 data bits, no parity, one stop
        cfg_eight = 1'b1; cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_two_stop = 1'b0;
        for (int v = 0; v < 256; v++) xfer(8'(v));

        // R4 / R5: queueing behind a running frame, write while full ignored
        @(negedge clk); tx_wr = 1'b1; tx_data = 8'hA1;
        @(negedge clk); tx_wr = 1'b0;
        chk(!tx_empty, "R4", int'(tx_empty), 0);
        chk(!tx_end, "R4", int'(tx_end), 0);
        @(negedge clk);
        chk(tx_empty, "R4", int'(tx_empty), 1);
        chk(!txd, "R4", int'(txd), 0);
        write_tx(8'hB2);
        chk(!tx_empty, "R4", int'(tx_empty), 0);
        write_tx(8'hC3);
        wait_full("R4");
        chk(rx_data == 8'hA1, "R4", int'(rx_data), 'hA1);
        chk(!tx_end, "R4", int'(tx_end), 0);
        read_rx();
        wait_full("R4");
        chk(rx_data == 8'hB2, "R5", int'(rx_data), 'hB2);
        read_rx();
        wait_tx_end();
        chk(tx_empty, "R4", int'(tx_empty), 1);
        repeat (300) @(negedge clk);
        chk(!rx_full, "R5", int'(rx_full), 0);

        // R6: overrun keeps the unread character
        write_tx(8'h5E);
        wait_full("R6");
        wait_tx_end();
        write_tx(8'h17);
        @(negedge clk);
        wait_tx_end();
        repeat (20) @(negedge clk);
        chk(rx_ovr, "R6", int'(rx_ovr), 1);
        chk(rx_full, "R6", int'(rx_full), 1);
        chk(rx_data == 8'h5E, "R6", int'(rx_data), 'h5E);
        read_rx();
        chk(!rx_ovr, "R6", int'(rx_ovr), 0);
        chk(!rx_full, "R6", int'(rx_full), 0);

        // R7: stop bit low
        drive_raw(8'h96, 1'b0, 1'b0);
        chk(rx_full, "R7", int'(rx_full), 1);
        chk(rx_ferr, "R7", int'(rx_ferr), 1);
        chk(!rx_perr, "R7", int'(rx_perr), 0);
        chk(rx_data == 8'h96, "R7", int'(rx_data), 'h96);
        read_rx();
        chk(!rx_ferr, "R7", int'(rx_ferr), 0);

        // R8: wrong parity, even mode
        cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        drive_raw(8'h6B, 1'b1, 1'b1);
        chk(rx_full, "R8", int'(rx_full), 1);
        chk(rx_perr, "R8", int'(rx_perr), 1);
        chk(!rx_ferr, "R8", int'(rx_ferr), 0);
        read_rx();
        drive_raw(8'h6B, 1'b0, 1'b1);
        chk(rx_full && !rx_perr, "R8", int'(rx_perr), 0);
        read_rx();
        cfg_par_en = 1'b0;

        // R9: runt start pulse
        @(negedge clk); drv = 1'b0;
        repeat (4) @(negedge clk); drv = 1'b1;
        repeat (300) @(negedge clk);
        chk(!rx_full, "R9", int'(rx_full), 0);
        chk(!rx_ferr, "R9", int'(rx_ferr), 0);
        drive_raw(8'h3C, 1'b0, 1'b1);
        chk(rx_full, "R9", int'(rx_full), 1);
        chk(rx_data == 8'h3C, "R9", int'(rx_data), 'h3C);
        read_rx();
        loop_sel = 1'b1;

        // R10: divider of 2, 9 low bits of 48 clocks minus tick phase
        cfg_div = 8'd2;
        repeat (10) @(negedge clk);
        measure_zero(430, 432, "R10");

        // R11: external clock of 4 clocks per tick
        cfg_div = 8'd0;
        ext_run = 1'b1;
        cfg_ext_clk = 1'b1;
        repeat (20) @(negedge clk);
        chk(!sclk_oe, "R11", int'(sclk_oe), 0);
        measure_zero(573, 576, "R11");
        cfg_ext_clk = 1'b0;
        ext_run = 1'b0;
        @(negedge clk);
        chk(sclk_oe, "R12", int'(sclk_oe), 1);
        cfg_clk_out_en = 1'b0;
        @(negedge clk);
        chk(!sclk_oe, "R12", int'(sclk_oe), 0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule